// File: doc/BRIEF.md
# Data-processing ALU with flags

This block is the execute stage of a 32-bit integer datapath. It takes a register operand A, a pre-shifted operand B together with the carry bit that the shifter produced, and a 4-bit operation code. It returns the result of one of sixteen operations: bitwise logic, add and subtract in both operand orders, carry-chained add and subtract, and four test-only forms that only set flags. It also produces a write-enable for the destination register.

The condition flags N, Z, C and V live in this block. They are loaded on the rising clock edge whenever flag setting is requested. One case is handled differently: when a result is written to register 15 with flag setting requested, the block does not load the flags. It raises a one-cycle mode-restore strobe instead, and separate logic restores the processor mode.

The result and the write-enable are combinational. The flags and both strobes are registered, so they appear one clock after the inputs that caused them.

Top module: `dp_alu`

## Requirements
- R1: The result depends on `op` as follows. 0: A&B. 1: A^B. 2: A−B. 3: B−A. 4: A+B. 5: A+B+cur_c. 6: A−B−1+cur_c. 7: B−A−1+cur_c. 8: A&B. 9: A^B. 10: A−B. 11: A+B. 12: A|B. 13: B. 14: A&~B. 15: ~B. All arithmetic is modulo 2^32.
- R2: `wr_en` is 0 when `op[3:2]` is 2'b10 (codes 8 to 11). It is 1 for every other code.
- R3: When `set_flags` is 0, the four flags keep their values after the clock edge and `flag_upd` is 0.
- R4: For the logical codes 0, 1, 8, 9, 12, 13, 14 and 15 with flags updated, N is result bit 31, Z is 1 exactly when the result is zero, C takes `sh_carry`, and V keeps its value.
- R5: For codes 2, 3, 6, 7 and 10, the flags follow a subtraction of the minuend minus the subtrahend. The minuend is A for codes 2, 6 and 10, and B for codes 3 and 7. C is 1 when no borrow occurs. V is 1 when the operand signs differ and the result sign differs from the minuend.
- R6: The carry-chained codes 5, 6 and 7 use `cur_c` as the carry-in. For codes 2, 3 and 10 the carry-in is fixed at 1, and for codes 4 and 11 it is fixed at 0.
- R7: For codes 4, 5 and 11, the flags follow an addition. C is the carry out of bit 31. V is 1 when both operands have the same sign and the result sign differs.
- R8: When `wr_en` is 1, `set_flags` is 1 and `dst` is 15, the next edge sets `mode_rst` to 1 for one cycle, sets `flag_upd` to 0, and leaves all flags unchanged. A test code (8 to 11) with `dst` 15 updates the flags normally.
- R9: A synchronous reset clears N, Z, C and V, `flag_upd` and `mode_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 32 | Operand A (register value) |
| opb | input | 32 | Operand B (shifted operand) |
| op | input | 4 | Operation code |
| sh_carry | input | 1 | Carry-out of the shifter |
| cur_c | input | 1 | Current carry flag used by the carry-chained codes |
| set_flags | input | 1 | Request a flag update |
| dst | input | 4 | Destination register index |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write-enable |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_upd | output | 1 | Registered strobe: the flags were loaded on the last edge |
| mode_rst | output | 1 | Registered strobe: a mode restore was requested |

## Verification
In a single cycle, writing register 15 and requesting flags both apply. The block must then choose the mode-restore strobe over the flag update. The bench provokes this with directed cases that write register 15 with flags requested, right after other cases have left distinctive flag values. It also provokes it with random traffic in which the destination is often 15. A reference model decides in each cycle whether the restore or the update applies, and the bench checks that `mode_rst` and `flag_upd` are never raised together and that the flags stay as they were. Test codes aimed at register 15 confirm that a restore needs an actual write.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 32,
  parameter int RB = 4,
  parameter int LINK = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [3:0]    op,
  input  logic          sh_carry,
  input  logic          cur_c,
  input  logic          set_flags,
  input  logic [RB-1:0] dst,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_upd,
  output logic          mode_rst
);
  localparam int MSB = W - 1;
  localparam logic [RB-1:0] LINK_IDX = RB'(LINK);

  logic [W-1:0] x, y, lres;
  logic         ci, arith;
  logic [W:0]   sum;
  logic         restore, upd, ovf;

  always_comb begin
    x = opa; y = opb; ci = 1'b0; arith = 1'b1; lres = '0;
    case (op)
      4'h2, 4'hA: begin y = ~opb; ci = 1'b1; end
      4'h3:       begin x = opb; y = ~opa; ci = 1'b1; end
      4'h4, 4'hB: ;
      4'h5:       ci = cur_c;
      4'h6:       begin y = ~opb; ci = cur_c; end
      4'h7:       begin x = opb; y = ~opa; ci = cur_c; end
      default: begin
        arith = 1'b0;
        case (op)
          4'h0, 4'h8: lres = opa & opb;
          4'h1, 4'h9: lres = opa ^ opb;
          4'hC:       lres = opa | opb;
          4'hD:       lres = opb;
          4'hE:       lres = opa & ~opb;
          default:    lres = ~opb;
        endcase
      end
    endcase
  end

  assign sum     = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign result  = arith ? sum[MSB:0] : lres;
  assign ovf     = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  assign wr_en   = op[3:2] != 2'b10;
  assign restore = wr_en && set_flags && (dst == LINK_IDX);
  assign upd     = set_flags && !restore;

  always_ff @(posedge clk) begin
    if (rst) begin
      {flag_n, flag_z, flag_c, flag_v} <= 4'b0000;
      flag_upd <= 1'b0;
      mode_rst <= 1'b0;
    end else begin
      flag_upd <= upd;
      mode_rst <= restore;
      if (upd) begin
        flag_n <= result[MSB];
        flag_z <= result == '0;
        flag_c <= arith ? sum[W] : sh_carry;
        if (arith) flag_v <= ovf;
      end
    end
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int RB = 4,
  parameter int LINK = 15
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op,
  input logic          set_flags,
  input logic [RB-1:0] dst,
  input logic          wr_en,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_c,
  input logic          flag_v,
  input logic          flag_upd,
  input logic          mode_rst
);
  logic [3:0] fl;
  assign fl = {flag_n, flag_z, flag_c, flag_v};

  p_test_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
    (op[3:2] == 2'b10) |-> !wr_en);
  p_other_write_r2: assert property (@(posedge clk) disable iff (rst)
    (op[3:2] != 2'b10) |-> wr_en);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> ($stable(fl) && !flag_upd));
  p_logic_v_r4: assert property (@(posedge clk) disable iff (rst)
    (set_flags && !op[1] && op[3:2] != 2'b01 && !(wr_en && dst == RB'(LINK))) |=> $stable(flag_v));
  p_restore_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && set_flags && dst == RB'(LINK)) |=> (mode_rst && !flag_upd && $stable(fl)));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(mode_rst && flag_upd));
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (fl == 4'b0000 && !flag_upd && !mode_rst));
endmodule

bind dp_alu dp_alu_chk #(.RB(RB), .LINK(LINK)) u_chk (
  .clk(clk), .rst(rst), .op(op), .set_flags(set_flags), .dst(dst),
  .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
  .flag_v(flag_v), .flag_upd(flag_upd), .mode_rst(mode_rst)
);

// File: tb/dp_alu_tb.sv
`timescale 1ns/1ps
module dp_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  op = '0, dst = '0;
  logic        sh_carry = 1'b0, cur_c = 1'b0, set_flags = 1'b0;
  logic [31:0] result;
  logic        wr_en, flag_n, flag_z, flag_c, flag_v, flag_upd, mode_rst;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit m_n = 0, m_z = 0, m_c = 0, m_v = 0;

  always #4 clk = ~clk;

  dp_alu u_dut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op(op), .sh_carry(sh_carry),
    .cur_c(cur_c), .set_flags(set_flags), .dst(dst), .result(result),
    .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .flag_upd(flag_upd), .mode_rst(mode_rst)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sub_ref(input logic [31:0] m, input logic [31:0] s, input bit ci,
                         output logic [31:0] r, output bit c, output bit v);
    longint d, sd;
    d  = longint'({32'b0, m}) - longint'({32'b0, s}) - (ci ? 0 : 1);
    sd = longint'({{32{m[31]}}, m}) - longint'({{32{s[31]}}, s}) - (ci ? 0 : 1);
    r = d[31:0];
    c = d >= 0;
    v = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
  endtask

  task automatic add_ref(input logic [31:0] p, input logic [31:0] q, input bit ci,
                         output logic [31:0] r, output bit c, output bit v);
    longint d, sd;
    d  = longint'({32'b0, p}) + longint'({32'b0, q}) + (ci ? 1 : 0);
    sd = longint'({{32{p[31]}}, p}) + longint'({{32{q[31]}}, q}) + (ci ? 1 : 0);
    r = d[31:0];
    c = d[32];
    v = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [3:0] o,
                      input bit shc, input bit cc, input bit sf, input logic [3:0] d);
    logic [31:0] er;
    bit ec, ev, arith, ew, erst, eupd;
    string rq;
    opa = a; opb = b; op = o; sh_carry = shc; cur_c = cc; set_flags = sf; dst = d;
    #1;
    arith = 1'b1; ec = 0; ev = 0; er = '0;
    case (o)
      4'h0, 4'h8: begin er = a & b; arith = 0; end
      4'h1, 4'h9: begin er = a ^ b; arith = 0; end
      4'hC: begin er = a | b; arith = 0; end
      4'hD: begin er = b; arith = 0; end
      4'hE: begin er = a & ~b; arith = 0; end
      4'hF: begin er = ~b; arith = 0; end
      4'h2, 4'hA: sub_ref(a, b, 1'b1, er, ec, ev);
      4'h3: sub_ref(b, a, 1'b1, er, ec, ev);
      4'h6: sub_ref(a, b, cc, er, ec, ev);
      4'h7: sub_ref(b, a, cc, er, ec, ev);
      4'h4, 4'hB: add_ref(a, b, 1'b0, er, ec, ev);
      default: add_ref(a, b, cc, er, ec, ev);
    endcase
    rq = (o inside {4'h5, 4'h6, 4'h7}) ? "R6" : "R1";
    chk(result == er, rq, "result", result, er);
    ew = !(o inside {[4'h8:4'hB]});
    chk(wr_en == ew, "R2", "wr_en", wr_en, ew);
    erst = ew && sf && d == 4'd15;
    eupd = sf && !erst;
    if (eupd) begin
      m_n = er[31]; m_z = er == 0;
      m_c = arith ? ec : shc;
      if (arith) m_v = ev;
    end
    rq = !sf ? "R3" : erst ? "R8" : !arith ? "R4" :
         (o inside {4'h4, 4'h5, 4'hB}) ? "R7" : "R5";
    @(negedge clk);
    chk(flag_n == m_n, rq, "flag_n", flag_n, m_n);
    chk(flag_z == m_z, rq, "flag_z", flag_z, m_z);
    chk(flag_c == m_c, rq, "flag_c", flag_c, m_c);
    chk(flag_v == m_v, rq, "flag_v", flag_v, m_v);
    chk(flag_upd == eupd, rq, "flag_upd", flag_upd, eupd);
    chk(mode_rst == erst, "R8", "mode_rst", mode_rst, erst);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk({flag_n, flag_z, flag_c, flag_v} == 4'b0, "R9", "flags", {flag_n, flag_z, flag_c, flag_v}, 0);
    chk(!flag_upd && !mode_rst, "R9", "strobes", {flag_upd, mode_rst}, 0);
    // R1 / R4 logical codes
    for (int k = 0; k < 16; k++)
      step(32'hF0F0_1234, 32'h0FF0_8765, 4'(k), k[0], k[1], 1'b1, 4'd3);
    // R7 addition overflow and carry
    step(32'h7FFF_FFFF, 32'h1, 4'h4, 0, 0, 1, 4'd1);
    step(32'hFFFF_FFFF, 32'h1, 4'hB, 0, 0, 1, 4'd1);
    step(32'hFFFF_FFFF, 32'h0, 4'h5, 0, 1, 1, 4'd2);
    // R4 V held over a logical op
    step(32'h8000_0000, 32'h8000_0000, 4'h4, 0, 0, 1, 4'd1);
    step(32'h0, 32'h0, 4'hD, 1, 0, 1, 4'd1);
    // R5 / R6 subtraction corners
    step(32'h0, 32'h1, 4'h2, 0, 0, 1, 4'd4);
    step(32'h8000_0000, 32'h1, 4'hA, 0, 0, 1, 4'd4);
    step(32'h5, 32'h5, 4'h6, 0, 0, 1, 4'd4);
    step(32'h5, 32'h5, 4'h6, 0, 1, 1, 4'd4);
    step(32'h1, 32'h0, 4'h3, 0, 0, 1, 4'd4);
    step(32'h3, 32'h7, 4'h7, 0, 0, 1, 4'd4);
    // R3 no update
    step(32'h0, 32'h0, 4'h2, 1, 1, 0, 4'd5);
    // R8 restore versus test-only writes to r15
    step(32'h1, 32'h1, 4'h2, 0, 0, 1, 4'd15);
    step(32'h8000_0000, 32'h0, 4'hD, 1, 0, 1, 4'd15);
    step(32'h1, 32'h1, 4'hA, 0, 0, 1, 4'd15);
    step(32'h8000_0000, 32'h0, 4'h9, 1, 0, 1, 4'd15);
    step(32'h2, 32'h3, 4'h4, 0, 0, 0, 4'd15);
    // random traffic, r15 often
    for (int i = 0; i < 600; i++)
      step($urandom, ($urandom_range(0, 3) == 0) ? opa : $urandom, 4'($urandom),
           1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 2) == 0) ? 4'd15 : 4'($urandom));
    // R9 reset again after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk({flag_n, flag_z, flag_c, flag_v, flag_upd, mode_rst} == 6'b0, "R9", "post-reset",
        {flag_n, flag_z, flag_c, flag_v, flag_upd, mode_rst}, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule